// File: doc/BRIEF.md
# Serial Configuration Port with Row Strobes

This block is the serial port through which a configuration array is loaded and checked. Four shared pins are involved: a serial clock, serial data in, a mode pin and a pin that serves as serial data out. An active-low enable pin decides what these pins do. When the enable pin is high, the pins are plain general-purpose inputs, and the clock pin is a plain clock. When the enable pin is low, a three-state controller (idle, command, execute) listens to the mode and data-in pins on each rising serial-clock edge.

In the command state the controller collects a 5-bit command code. In the execute state it shifts a one-hot row-address register, shifts a data register built from two halves, reads out a fixed 8-bit device code, or walks the address register. The array itself lies outside the block. It is driven through a row-write strobe and a row-read strobe, together with the selected row index. All pins are sampled with the system clock. Serial-clock edges are found from the synchronised pin.

Top module: `isp_serial_port`

## Requirements
- R1: While `cfg_en_n` is 1, `gp_data` equals {`pin_mode`, `pin_sdo_in`, `pin_sdi`}, `gp_clk` follows `pin_sclk` and `sdo_oe` is 0. While `cfg_en_n` is 0, `gp_data` and `gp_clk` are 0 and `sdo_oe` is 1.
- R2: A return of `cfg_en_n` to 1 puts the controller back in idle and abandons any command in progress. In idle, rising serial-clock edges with mode 0 change no register.
- R3: From idle, a rising edge with mode 1 enters the command state. Each following mode-0 edge shifts `pin_sdi` into a 5-bit code, first bit = bit 0. A mode-1 edge then starts executing the code. The codes are: address shift 0x01, data shift 0x02, program 0x07, verify 0x0A, read code 0x16.
- R4: In the execute state, a mode-1 edge with `pin_sdi`=1 returns to the command state, and one with `pin_sdi`=0 returns to idle.
- R5: Under address shift, each mode-0 edge shifts `pin_sdi` into address bit ADDR_W-1 and moves all bits one position toward bit 0. `sdo_out` presents address bit 0.
- R6: Under data shift, the data register works as one DATA_W-bit chain. The upper half (bits DATA_W/2 and up) feeds the lower half, new bits enter at the top and `sdo_out` presents bit 0. `row_data` equals the whole register.
- R7: Under read code, `sdo_out` gives 0x0B starting with bit 0 (1,1,0,1,0,0,0,0), one bit per mode-0 edge, and 0 after that.
- R8: Program raises `row_wr` for exactly one cycle for each address bit that is 1, in ascending row order, with `row_sel` equal to that row and `row_data` equal to the data register.
- R9: Verify raises `row_rd` once, for the lowest set address bit, and loads `row_rdata` into the data register. With no bit set there is no read and the data register is unchanged.
- R10: `sdo_out` changes only after a falling serial-clock edge. Undefined codes shift no register and present 0 on `sdo_out`.
- R11: After reset the state is idle, the address, data and code registers are 0, `sdo_out` is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en_n | input | 1 | Active-low configuration enable |
| pin_sclk | input | 1 | Serial clock / general clock pin |
| pin_sdi | input | 1 | Serial data in / general input |
| pin_mode | input | 1 | Mode / general input |
| pin_sdo_in | input | 1 | Input side of the data-out pin |
| sdo_out | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable of the data-out pin |
| gp_data | output | 3 | General-purpose inputs seen by the logic |
| gp_clk | output | 1 | General clock seen by the logic |
| row_wr | output | 1 | Row write strobe |
| row_rd | output | 1 | Row read strobe |
| row_sel | output | $clog2(ADDR_W) | Selected row index |
| row_data | output | DATA_W | Data register contents |
| row_rdata | input | DATA_W | Data returned for the read row |

## Verification
The bench builds the block with the full sizes: a 160-bit data register, a 110-row address register and code 0x0B. At these sizes the bench can check the split point between the two data halves at bit 80, the top address row 109 in the program walk, and the last step of the row scanner. Random address patterns sweep the program walk. Directed cases cover verify with two set rows and with none, an undefined code, and the enable pin dropped in the middle of a command.

// File: rtl/isp_pkg.sv
package isp_pkg;

    localparam int CMD_W = 5;

    localparam logic [CMD_W-1:0] CODE_ADDR = 5'h01;
    localparam logic [CMD_W-1:0] CODE_DATA = 5'h02;
    localparam logic [CMD_W-1:0] CODE_PROG = 5'h07;
    localparam logic [CMD_W-1:0] CODE_VER  = 5'h0A;
    localparam logic [CMD_W-1:0] CODE_ID   = 5'h16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_EXEC = 2'd2
    } isp_state_e;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADDR = 3'd1,
        OP_DATA = 3'd2,
        OP_PROG = 3'd3,
        OP_VER  = 3'd4,
        OP_ID   = 3'd5
    } isp_op_e;

    function automatic isp_op_e decode_cmd(input logic [CMD_W-1:0] code);
        case (code)
            CODE_ADDR: return OP_ADDR;
            CODE_DATA: return OP_DATA;
            CODE_PROG: return OP_PROG;
            CODE_VER:  return OP_VER;
            CODE_ID:   return OP_ID;
            default:   return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/isp_shreg.sv
module isp_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift,
    input  logic         sin,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= ld_val;
        else if (shift) q <= {sin, q[W-1:1]};
    end
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
    import isp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_n,
    input  logic       sclk,
    input  logic       sdi,
    input  logic       mode,
    output logic       sdi_s,
    output logic       en_act,
    output logic       fall_ev,
    output isp_state_e state_q,
    output isp_op_e    op_q,
    output logic       addr_shift,
    output logic       data_shift,
    output logic       id_shift,
    output logic       id_load,
    output logic       scan_start
);
    logic [2:0]       sclk_sy;
    logic [1:0]       sdi_sy, mode_sy, en_sy;
    logic [CMD_W-1:0] code_q;
    logic             rise_ev, mode_s;
    isp_op_e          op_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sy <= '0;
            sdi_sy  <= '0;
            mode_sy <= '0;
            en_sy   <= 2'b11;
        end else begin
            sclk_sy <= {sclk_sy[1:0], sclk};
            sdi_sy  <= {sdi_sy[0], sdi};
            mode_sy <= {mode_sy[0], mode};
            en_sy   <= {en_sy[0], en_n};
        end
    end

    assign sdi_s   = sdi_sy[1];
    assign mode_s  = mode_sy[1];
    assign en_act  = ~en_sy[1];
    assign rise_ev = en_act & sclk_sy[1] & ~sclk_sy[2];
    assign fall_ev = en_act & ~sclk_sy[1] & sclk_sy[2];
    assign op_next = decode_cmd(code_q);

    always_ff @(posedge clk) begin
        if (rst || !en_act) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            if (rst) code_q <= '0;
        end else if (rise_ev) begin
            case (state_q)
                ST_IDLE: if (mode_s) begin
                    state_q <= ST_CMD;
                    code_q  <= '0;
                end
                ST_CMD: if (mode_s) begin
                    state_q <= ST_EXEC;
                    op_q    <= op_next;
                end else begin
                    code_q <= {sdi_s, code_q[CMD_W-1:1]};
                end
                ST_EXEC: if (mode_s) begin
                    op_q    <= OP_NONE;
                    code_q  <= '0;
                    state_q <= sdi_s ? ST_CMD : ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        logic exec_shift;
        exec_shift = rise_ev && state_q == ST_EXEC && !mode_s;
        addr_shift = exec_shift && op_q == OP_ADDR;
        data_shift = exec_shift && op_q == OP_DATA;
        id_shift   = exec_shift && op_q == OP_ID;
        id_load    = rise_ev && state_q == ST_CMD && mode_s && op_next == OP_ID;
        scan_start = rise_ev && state_q == ST_CMD && mode_s &&
                     (op_next == OP_PROG || op_next == OP_VER);
    end
endmodule

// File: rtl/isp_row_scan.sv
module isp_row_scan
    import isp_pkg::*;
#(
    parameter int ADDR_W = 110,
    localparam int IDX_W = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_act,
    input  logic              start,
    input  isp_op_e           op,
    input  logic [ADDR_W-1:0] rows,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [IDX_W-1:0]  idx_q
);
    logic busy_q, hit;

    assign hit    = busy_q && rows[idx_q];
    assign wr_stb = hit && op == OP_PROG;
    assign rd_stb = hit && op == OP_VER;

    always_ff @(posedge clk) begin
        if (rst || !en_act) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (rd_stb || idx_q == IDX_W'(ADDR_W - 1)) busy_q <= 1'b0;
            else                                       idx_q  <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/isp_serial_port.sv
module isp_serial_port
    import isp_pkg::*;
#(
    parameter int          DATA_W  = 160,
    parameter int          ADDR_W  = 110,
    parameter logic [7:0]  ID_CODE = 8'h0B,
    localparam int         HALF    = DATA_W / 2,
    localparam int         IDX_W   = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en_n,
    input  logic              pin_sclk,
    input  logic              pin_sdi,
    input  logic              pin_mode,
    input  logic              pin_sdo_in,
    output logic              sdo_out,
    output logic              sdo_oe,
    output logic [2:0]        gp_data,
    output logic              gp_clk,
    output logic              row_wr,
    output logic              row_rd,
    output logic [IDX_W-1:0]  row_sel,
    output logic [DATA_W-1:0] row_data,
    input  logic [DATA_W-1:0] row_rdata
);
    logic              sdi_s, en_act, fall_ev;
    logic              addr_shift, data_shift, id_shift, id_load, scan_start;
    isp_state_e        state_q;
    isp_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] dat_q;
    logic [7:0]        id_q;
    logic              sdo_q;

    assign gp_data = cfg_en_n ? {pin_mode, pin_sdo_in, pin_sdi} : 3'b000;
    assign gp_clk  = cfg_en_n & pin_sclk;
    assign sdo_oe  = ~cfg_en_n;

    isp_ctrl u_ctrl (
        .clk(clk), .rst(rst), .en_n(cfg_en_n), .sclk(pin_sclk),
        .sdi(pin_sdi), .mode(pin_mode), .sdi_s(sdi_s), .en_act(en_act),
        .fall_ev(fall_ev), .state_q(state_q), .op_q(op_q),
        .addr_shift(addr_shift), .data_shift(data_shift),
        .id_shift(id_shift), .id_load(id_load), .scan_start(scan_start)
    );

    isp_shreg #(.W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .shift(addr_shift), .sin(sdi_s),
        .load(1'b0), .ld_val('0), .q(addr_q)
    );

    isp_shreg #(.W(8)) u_id (
        .clk(clk), .rst(rst), .shift(id_shift), .sin(1'b0),
        .load(id_load), .ld_val(ID_CODE), .q(id_q)
    );

    for (genvar g = 0; g < 2; g++) begin : g_half
        logic sin_h;
        if (g == 1) begin : g_top
            assign sin_h = sdi_s;
        end else begin : g_bot
            assign sin_h = dat_q[HALF];
        end
        isp_shreg #(.W(HALF)) u_half (
            .clk(clk), .rst(rst), .shift(data_shift), .sin(sin_h),
            .load(row_rd), .ld_val(row_rdata[g*HALF +: HALF]),
            .q(dat_q[g*HALF +: HALF])
        );
    end

    isp_row_scan #(.ADDR_W(ADDR_W)) u_scan (
        .clk(clk), .rst(rst), .en_act(en_act), .start(scan_start),
        .op(op_q), .rows(addr_q), .wr_stb(row_wr), .rd_stb(row_rd),
        .idx_q(row_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
        end else if (fall_ev) begin
            case (op_q)
                OP_ADDR: sdo_q <= addr_q[0];
                OP_DATA: sdo_q <= dat_q[0];
                OP_ID:   sdo_q <= id_q[0];
                default: sdo_q <= 1'b0;
            endcase
        end
    end

    assign sdo_out  = sdo_q;
    assign row_data = dat_q;
endmodule

// File: rtl/isp_serial_port_chk.sv
module isp_serial_port_chk
    import isp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       row_wr,
    input logic       row_rd,
    input logic       sdo_out,
    input logic       fall_ev,
    input logic       en_act,
    input isp_state_e state_q
);
    // R8 / R9: write and read strobes never coincide
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(row_wr && row_rd));

    // R8: row writes happen only while a command executes
    a_r8_wr_in_exec: assert property (@(posedge clk) disable iff (rst)
        row_wr |-> state_q == ST_EXEC);

    // R9: a verify issues a single read pulse
    a_r9_single_read: assert property (@(posedge clk) disable iff (rst)
        row_rd |=> !row_rd);

    // R10: serial output moves only after a falling serial-clock edge
    a_r10_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
        !fall_ev |=> $stable(sdo_out));

    // R2: losing the enable returns the controller to idle
    a_r2_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !en_act |=> state_q == ST_IDLE);
endmodule

bind isp_serial_port isp_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .row_wr(row_wr), .row_rd(row_rd),
    .sdo_out(sdo_out), .fall_ev(fall_ev), .en_act(en_act),
    .state_q(state_q)
);

// File: tb/tb_isp_serial_port.sv
module tb_isp_serial_port;
    localparam int DW = 160;
    localparam int AW = 110;
    localparam int IW = $clog2(AW);

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_en_n = 1'b1, pin_sclk = 1'b0, pin_sdi = 1'b0, pin_mode = 1'b0;
    logic pin_sdo_in = 1'b0;
    logic sdo_out, sdo_oe, gp_clk, row_wr, row_rd;
    logic [2:0]    gp_data;
    logic [IW-1:0] row_sel;
    logic [DW-1:0] row_data, row_rdata;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] rdata_of(input logic [IW-1:0] s);
        return {20{8'h5A ^ {1'b0, s}}};
    endfunction
    assign row_rdata = rdata_of(row_sel);

    isp_serial_port dut (
        .clk(clk), .rst(rst), .cfg_en_n(cfg_en_n), .pin_sclk(pin_sclk),
        .pin_sdi(pin_sdi), .pin_mode(pin_mode), .pin_sdo_in(pin_sdo_in),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe), .gp_data(gp_data),
        .gp_clk(gp_clk), .row_wr(row_wr), .row_rd(row_rd),
        .row_sel(row_sel), .row_data(row_data), .row_rdata(row_rdata)
    );

    // strobe monitor
    int wr_n = 0, rd_n = 0, wr_bad_data = 0;
    int wr_sel[128];
    int rd_sel;
    logic [DW-1:0] dat_ref;
    always @(negedge clk) begin
        if (row_wr) begin
            if (wr_n < 128) wr_sel[wr_n] = int'(row_sel);
            if (row_data !== dat_ref) wr_bad_data++;
            wr_n++;
        end
        if (row_rd) begin
            rd_sel = int'(row_sel);
            rd_n++;
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic m, input logic d);
        pin_mode = m; pin_sdi = d;
        repeat (2) @(negedge clk);
        pin_sclk = 1'b1;
        repeat (5) @(negedge clk);
        pin_sclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic start_cmd(input logic [4:0] code);
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) pulse(1'b0, code[i]);
        pulse(1'b1, 1'b0);
    endtask

    task automatic shift_addr(input logic [AW-1:0] nv, output logic [AW-1:0] old);
        start_cmd(5'h01);
        for (int i = 0; i < AW; i++) begin
            old[i] = sdo_out;
            pulse(1'b0, nv[i]);
        end
        pulse(1'b1, 1'b0);
    endtask

    task automatic shift_data(input logic [DW-1:0] nv, output logic [DW-1:0] old);
        start_cmd(5'h02);
        for (int i = 0; i < DW; i++) begin
            old[i] = sdo_out;
            pulse(1'b0, nv[i]);
        end
        pulse(1'b1, 1'b0);
    endtask

    task automatic run_prog(input logic [AW-1:0] a, input string req);
        int exp_n, k;
        logic ok;
        wr_n = 0; wr_bad_data = 0;
        start_cmd(5'h07);
        repeat (AW + 20) @(negedge clk);
        pulse(1'b1, 1'b0);
        exp_n = $countones(a);
        check({req, " write count"}, DW'(wr_n), DW'(exp_n));
        ok = 1'b1; k = 0;
        for (int r = 0; r < AW; r++)
            if (a[r]) begin
                if (k >= wr_n || wr_sel[k] != r) ok = 1'b0;
                k++;
            end
        check({req, " write rows ascending"}, DW'(ok), DW'(1));
        check({req, " write data"}, DW'(wr_bad_data), DW'(0));
    endtask

    initial begin
        #(190_000 * 5);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a1, a2, a3, old_a;
        logic [DW-1:0] d1, d2, old_d;
        logic [7:0]    idv;
        void'($urandom(32'd1016));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check("R11 sdo", DW'(sdo_out), DW'(0));
        check("R11 strobes", DW'({row_wr, row_rd}), DW'(0));
        check("R11 data reg", row_data, '0);

        // R1 disabled: pins pass through
        pin_mode = 1; pin_sdo_in = 0; pin_sdi = 1; pin_sclk = 1; #1;
        check("R1 gp_data passthru", DW'(gp_data), DW'(3'b101));
        check("R1 gp_clk passthru", DW'(gp_clk), DW'(1));
        check("R1 sdo_oe off", DW'(sdo_oe), DW'(0));
        pin_mode = 0; pin_sdo_in = 1; pin_sdi = 0; pin_sclk = 0;
        @(negedge clk);
        check("R1 gp_data passthru 2", DW'(gp_data), DW'(3'b010));

        cfg_en_n = 1'b0; pin_sdo_in = 1; pin_mode = 1; pin_sdi = 1; #1;
        check("R1 gp_data gated", DW'(gp_data), DW'(0));
        check("R1 sdo_oe on", DW'(sdo_oe), DW'(1));
        pin_mode = 0; pin_sdi = 0;
        repeat (4) @(negedge clk);

        // R5 / R3 address shift
        a1 = '0;
        for (int i = 0; i < 6; i++) a1[$urandom_range(AW-1)] = 1'b1;
        a1[AW-1] = 1'b1;
        shift_addr(a1, old_a);
        check("R5 addr old after reset (R11)", DW'(old_a), DW'(0));
        a2 = {$urandom, $urandom, $urandom, $urandom};
        a2[0] = 1'b1; a2[AW-1] = 1'b1;
        shift_addr(a2, old_a);
        check("R5 addr readback", DW'(old_a), DW'(a1));

        // R6 data shift, half boundary
        for (int i = 0; i < DW/32; i++) d1[i*32 +: 32] = $urandom;
        shift_data(d1, old_d);
        check("R6 data old after reset", old_d, '0);
        check("R6 data register image", row_data, d1);
        for (int i = 0; i < DW/32; i++) d2[i*32 +: 32] = $urandom;
        shift_data(d2, old_d);
        check("R6 data readback", old_d, d1);
        check("R6 upper half", DW'(row_data[DW-1:DW/2]), DW'(d2[DW-1:DW/2]));
        dat_ref = d2;

        // R8 program walk
        run_prog(a2, "R8");

        // R4 chain: exec -> command -> read code, R7
        start_cmd(5'h01);
        pulse(1'b1, 1'b1);
        for (int i = 0; i < 5; i++) pulse(1'b0, 5'h16 >> i);
        pulse(1'b1, 1'b0);
        idv[0] = sdo_out;
        for (int i = 1; i < 8; i++) begin
            if (i == 2) begin
                // R10: mid-high phase sdo still shows previous bit
                pin_mode = 0; pin_sdi = 0;
                repeat (2) @(negedge clk);
                pin_sclk = 1'b1;
                repeat (5) @(negedge clk);
                check("R10 sdo holds while sclk high", DW'(sdo_out), DW'(1));
                pin_sclk = 1'b0;
                repeat (6) @(negedge clk);
            end else begin
                pulse(1'b0, 1'b0);
            end
            idv[i] = sdo_out;
        end
        check("R7 read code (R4 chained)", DW'(idv), DW'(8'h0B));
        pulse(1'b0, 1'b0);
        check("R7 zero after code", DW'(sdo_out), DW'(0));
        pulse(1'b1, 1'b0);

        // R9 verify: lowest set row 37
        a3 = '0; a3[37] = 1'b1; a3[90] = 1'b1;
        shift_addr(a3, old_a);
        check("R5 addr readback 2", DW'(old_a), DW'(a2));
        rd_n = 0;
        start_cmd(5'h0A);
        repeat (AW + 20) @(negedge clk);
        pulse(1'b1, 1'b0);
        check("R9 read count", DW'(rd_n), DW'(1));
        check("R9 read row", DW'(rd_sel), DW'(37));
        check("R9 loaded data", row_data, rdata_of(IW'(37)));

        // R9 verify with no set row
        shift_addr('0, old_a);
        d1 = row_data;
        rd_n = 0;
        start_cmd(5'h0A);
        repeat (AW + 20) @(negedge clk);
        pulse(1'b1, 1'b0);
        check("R9 no read when empty", DW'(rd_n), DW'(0));
        check("R9 data unchanged", row_data, d1);

        // R10 undefined code
        a1 = '0; a1[5] = 1'b1; a1[77] = 1'b1;
        shift_addr(a1, old_a);
        start_cmd(5'h1F);
        for (int i = 0; i < 6; i++) pulse(1'b0, 1'b1);
        check("R10 sdo zero on bad code", DW'(sdo_out), DW'(0));
        pulse(1'b1, 1'b0);
        check("R10 data untouched", row_data, d1);
        shift_addr(a1, old_a);
        check("R10 addr untouched", DW'(old_a), DW'(a1));

        // R2 enable drop mid-command
        pulse(1'b1, 1'b0);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b0);
        cfg_en_n = 1'b1;
        repeat (6) @(negedge clk);
        cfg_en_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
        shift_addr(a1, old_a);
        check("R2 idle after re-enable", DW'(old_a), DW'(a1));
        check("R2 data kept", row_data, d1);

        // random program walks
        dat_ref = row_data;
        for (int t = 0; t < 4; t++) begin
            a2 = '0;
            for (int i = 0; i < 1 + int'($urandom_range(9)); i++)
                a2[$urandom_range(AW-1)] = 1'b1;
            if (t == 0) a2[AW-1] = 1'b1;
            shift_addr(a2, old_a);
            run_prog(a2, "R8 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule